// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block supervises software by counting down from a chosen start value. A free-running prescaler gives the countdown its slow tick. Software must restart the countdown before it runs out. One tick before the count runs out, the block gives a single-cycle warning on the non-maskable interrupt request. At the end of the count it raises a system reset request, and that request stays high until the block itself is reset.

All control goes through one write port. A write carries a command bit (start or stop), an 8-bit start count and a 7-bit key. The block accepts a write only when its key is the bitwise complement of the key it last accepted. After reset, the first write is accepted with any key, and that key becomes the reference. Software therefore has to flip its key on every refresh or stop, so a runaway loop that replays one write cannot keep the watchdog quiet. A write with the wrong key changes nothing except a sticky error flag. A start is also the refresh operation: it reloads the count and restarts the prescaler.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped. `count` is 0 and `nmi_req`, `rst_req` and `key_err` are all low.
- R2: The first write after reset is accepted whatever its key, and its key becomes the reference key.
- R3: Every later write is accepted only if `wr_key` equals the last accepted key XOR 7'h7F. A rejected write leaves the count, the running state and the reference key unchanged.
- R4: A rejected write sets `key_err`, which then stays high until reset.
- R5: An accepted write with `wr_cmd` = 1 (start) loads `wr_count` into the count and sets `running`. This holds whether the watchdog was stopped or already running.
- R6: An accepted write with `wr_cmd` = 0 (stop) clears `running`, and the count then stays frozen.
- R7: While the watchdog runs, the count drops by one every DIV = 2**PRESC_W clock cycles. An accepted start restarts the prescaler, so the first decrement comes exactly DIV cycles after the edge that accepted the start.
- R8: `nmi_req` is high for exactly one cycle. It rises on the edge where a decrement takes the count from 2 to 1. A start value of 1 or 0 gives no warning.
- R9: A tick that arrives while the count is 1 or 0 sets the count to 0, clears `running` and raises `rst_req`. `rst_req` then holds until reset, and later writes have no effect on the count, `running` or `rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per command |
| wr_cmd | input | 1 | 1 = start/refresh, 0 = stop |
| wr_count | input | CNT_W (8) | Start value loaded by a start command |
| wr_key | input | KEY_W (7) | Key presented with the write |
| count | output | CNT_W (8) | Current countdown value |
| running | output | 1 | Countdown is active |
| nmi_req | output | 1 | One-cycle warning pulse, one tick before expiry |
| rst_req | output | 1 | System reset request, held until reset |
| key_err | output | 1 | Sticky flag: a write with a wrong key was seen |

## Verification
The in-line assertions check the following on every cycle:
- the count never moves by more than one step per tick;
- `nmi_req` only appears with a count of 1 and never lasts two cycles;
- `rst_req`, once high, stays high with the counter dead;
- a stopped counter stays frozen;
- the key register takes the key of each accepted write and holds it through rejected ones.

Only the bench scenarios can show the following:
- the chain of alternating keys across many writes;
- the exact cycle of the first decrement after a refresh that lands on a tick;
- the absence of a warning when the start value is 0 or 1;
- that writes made after expiry change nothing at the ports.

// File: rtl/kwdt_pkg.sv
// Package: shared encodings of the keyed watchdog.
// Assumes: a single command bit on the write port.
package kwdt_pkg;
    typedef enum logic {
        CMD_STOP  = 1'b0,
        CMD_START = 1'b1
    } kwdt_cmd_e;
endpackage

// File: rtl/kwdt_key_gate.sv
// Key gate: decides whether a write is accepted. The first write after
// reset arms the gate with any key. After that a write must carry the
// complement of the stored key. Keeps a sticky error flag for rejects.
// Assumes: wr_en is a single-cycle strobe in the clk domain.
module kwdt_key_gate #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept,
    output logic             key_err
);
    logic [KEY_W-1:0] key_q;
    logic             armed_q;
    logic             err_q;

    // Accept when unarmed, or when the key is the complement of the stored one
    always_comb begin
        accept = wr_en && (!armed_q || (wr_key == ~key_q));
    end

    // Store the accepted key; flag any rejected write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q   <= '0;
            armed_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (wr_en) begin
            if (accept) begin
                key_q   <= wr_key;
                armed_q <= 1'b1;
            end else begin
                err_q   <= 1'b1;
            end
        end
    end

    assign key_err = err_q;

    // R3
    key_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (key_q == $past(wr_key)));
    // R3
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(key_q));
    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/kwdt_prescaler.sv
// Prescaler: divides the clock by 2**PRESC_W to make the countdown tick.
// Restarts from zero on demand and stays at zero while disabled.
// Assumes: restart has priority over counting.
module kwdt_prescaler #(
    parameter int PRESC_W = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic tick
);
    logic [PRESC_W-1:0] cnt_q;

    // Tick on the last count of each period while enabled
    always_comb begin
        tick = enable && (cnt_q == {PRESC_W{1'b1}});
    end

    // Free-running divider with synchronous restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/kwdt_counter.sv
// Countdown core: loads the start value, decrements on each tick,
// raises a one-cycle warning on the step to 1, and latches the reset
// request at expiry.
// Assumes: load and halt come only from accepted writes; load has priority.
module kwdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             halt,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             nmi_req,
    output logic             rst_req
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] count_q;
    logic             running_q;
    logic             nmi_q;
    logic             rst_q;

    // Countdown state, warning pulse and sticky reset request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            running_q <= 1'b0;
            nmi_q     <= 1'b0;
            rst_q     <= 1'b0;
        end else begin
            nmi_q <= 1'b0;
            if (rst_q) begin
                count_q   <= '0;
                running_q <= 1'b0;
            end else if (load) begin
                count_q   <= load_val;
                running_q <= 1'b1;
            end else if (halt) begin
                running_q <= 1'b0;
            end else if (running_q && tick) begin
                if (count_q <= ONE) begin
                    count_q   <= '0;
                    running_q <= 1'b0;
                    rst_q     <= 1'b1;
                end else begin
                    count_q <= count_q - ONE;
                    nmi_q   <= (count_q == TWO);
                end
            end
        end
    end

    assign count   = count_q;
    assign running = running_q;
    assign nmi_req = nmi_q;
    assign rst_req = rst_q;

    // R7
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && tick && !load && !halt && !rst_q && count_q > ONE)
        |=> (count_q == $past(count_q) - ONE));
    // R6
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && !load && !rst_q) |=> $stable(count_q));
    // R8
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |=> !nmi_q);
    // R8
    nmi_at_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_q |-> (count_q == ONE));
    // R9
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> rst_q);
    // R9
    rst_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (!running_q && count_q == '0));
endmodule

// File: rtl/keyed_watchdog.sv
// Keyed watchdog top: joins the key gate, prescaler and countdown core.
// Only accepted writes reach the counter. A start restarts the prescaler.
// Assumes: one write per cycle at most; rst_n is synchronous to clk.
module keyed_watchdog
    import kwdt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int KEY_W   = 7,
    parameter int PRESC_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [KEY_W-1:0] wr_key,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             nmi_req,
    output logic             rst_req,
    output logic             key_err
);
    logic accept;
    logic tick;
    logic do_load;
    logic do_halt;

    // Split an accepted write into load or halt; nothing restarts after expiry
    always_comb begin
        do_load = accept && (wr_cmd == CMD_START) && !rst_req;
        do_halt = accept && (wr_cmd == CMD_STOP);
    end

    kwdt_key_gate #(.KEY_W(KEY_W)) gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_key  (wr_key),
        .accept  (accept),
        .key_err (key_err)
    );

    kwdt_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (running),
        .restart (do_load),
        .tick    (tick)
    );

    kwdt_counter #(.CNT_W(CNT_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .halt     (do_halt),
        .tick     (tick),
        .load_val (wr_count),
        .count    (count),
        .running  (running),
        .nmi_req  (nmi_req),
        .rst_req  (rst_req)
    );
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
    localparam int CNT_W   = 8;
    localparam int KEY_W   = 7;
    localparam int PRESC_W = 2;
    localparam int DIV     = 1 << PRESC_W;
    localparam int NVEC    = 8;

    // vector: cmd, count, key, exp_count, exp_running, exp_key_err
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 8'd50, 7'h2A, 8'd50, 1'b1, 1'b0},  // R2 first write, any key
        {1'b1, 8'd40, 7'h2A, 8'd50, 1'b1, 1'b1},  // R3 R4 same key rejected
        {1'b1, 8'd60, 7'h55, 8'd60, 1'b1, 1'b1},  // R5 refresh while running
        {1'b0, 8'd0,  7'h55, 8'd60, 1'b1, 1'b1},  // R3 stop with stale key
        {1'b0, 8'd0,  7'h2A, 8'd60, 1'b0, 1'b1},  // R6 stop accepted
        {1'b1, 8'd30, 7'h2A, 8'd60, 1'b0, 1'b1},  // R3 wrong key while stopped
        {1'b1, 8'd30, 7'h55, 8'd30, 1'b1, 1'b1},  // R5 start from stopped
        {1'b1, 8'd9,  7'h2A, 8'd9,  1'b1, 1'b1}   // R5 refresh
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_cmd = 1'b0;
    logic [CNT_W-1:0] wr_count = '0;
    logic [KEY_W-1:0] wr_key = '0;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             nmi_req;
    logic             rst_req;
    logic             key_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    keyed_watchdog #(.CNT_W(CNT_W), .KEY_W(KEY_W), .PRESC_W(PRESC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_count(wr_count), .wr_key(wr_key), .count(count),
        .running(running), .nmi_req(nmi_req), .rst_req(rst_req),
        .key_err(key_err)
    );

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // called at a negedge; leaves the bench at the negedge after the capture edge
    task automatic wr(input logic cmd, input int cnt, input int key);
        wr_en    = 1'b1;
        wr_cmd   = cmd;
        wr_count = CNT_W'(cnt);
        wr_key   = KEY_W'(key);
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual 1 expected 0 (run hung)");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 count", count, 0);
        check("R1 running", running, 0);
        check("R1 nmi_req", nmi_req, 0);
        check("R1 rst_req", rst_req, 0);
        check("R1 key_err", key_err, 0);

        // vector walk: key chain, loads, stops, rejects
        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v][25], int'(VEC[v][24:17]), int'(VEC[v][16:10]));
            check($sformatf("R3/R5/R6 vec%0d count", v), count, int'(VEC[v][9:2]));
            check($sformatf("R3/R5/R6 vec%0d running", v), running, int'(VEC[v][1]));
            check($sformatf("R4 vec%0d key_err", v), key_err, int'(VEC[v][0]));
        end

        // R7 first decrement exactly DIV cycles after the load
        wait_neg(DIV - 1);
        check("R7 before first tick", count, 9);
        wait_neg(1);
        check("R7 first tick", count, 8);

        // R7 refresh landing on a tick edge restarts the prescaler
        wait_neg(DIV - 1);
        wr(1'b1, 20, 7'h55);
        check("R5 refresh on tick", count, 20);
        wait_neg(DIV - 1);
        check("R7 restart hold", count, 20);
        wait_neg(1);
        check("R7 restart tick", count, 19);

        // R8 warning pulse, R9 expiry
        wr(1'b1, 3, 7'h2A);
        wait_neg(DIV);
        check("R7 count 2", count, 2);
        wait_neg(DIV - 1);
        check("R8 nmi low before", nmi_req, 0);
        wait_neg(1);
        check("R8 count 1", count, 1);
        check("R8 nmi high", nmi_req, 1);
        wait_neg(1);
        check("R8 nmi single cycle", nmi_req, 0);
        wait_neg(DIV - 2);
        check("R9 not yet expired", rst_req, 0);
        wait_neg(1);
        check("R9 rst_req", rst_req, 1);
        check("R9 running off", running, 0);
        check("R9 count 0", count, 0);

        // R9 writes after expiry have no effect
        wr(1'b1, 50, 7'h55);
        check("R9 post-expiry count", count, 0);
        check("R9 post-expiry running", running, 0);
        wait_neg(3 * DIV);
        check("R9 rst_req held", rst_req, 1);
        check("R4 key_err still set", key_err, 1);

        // R1 reset clears everything
        do_reset();
        check("R1 rst_req cleared", rst_req, 0);
        check("R1 key_err cleared", key_err, 0);

        // R2 arbitrary first key, R6 stop freezes
        wr(1'b1, 5, 7'h11);
        check("R2 start accepted", running, 1);
        wait_neg(2);
        wr(1'b0, 0, 7'h6E);
        check("R6 stopped", running, 0);
        wait_neg(5 * DIV);
        check("R6 frozen count", count, 5);
        check("R6 no reset", rst_req, 0);

        // R3 rejected write keeps the reference key
        wr(1'b1, 7, 7'h6E);
        check("R3 reject running", running, 0);
        check("R4 reject flag", key_err, 1);
        wr(1'b1, 7, 7'h11);
        check("R3 stored key kept", count, 7);
        check("R3 accepted after reject", running, 1);

        // R9 start value 0 expires at first tick, R8 no warning
        do_reset();
        wr(1'b1, 0, 7'h00);
        for (int i = 0; i < DIV - 1; i++) begin
            check("R8 no nmi from 0", nmi_req, 0);
            wait_neg(1);
        end
        check("R9 zero start not yet", rst_req, 0);
        wait_neg(1);
        check("R9 zero start expires", rst_req, 1);
        check("R8 no nmi at zero expiry", nmi_req, 0);

        // R8 start value 1 gives no warning
        do_reset();
        wr(1'b1, 1, 7'h05);
        for (int i = 0; i < DIV; i++) begin
            wait_neg(1);
            check("R8 no nmi from 1", nmi_req, 0);
        end
        check("R9 start 1 expires", rst_req, 1);

        finish_run();
    end
endmodule